// File: doc/BRIEF.md
# Dual-Port Scratch Buffer with Burst Readout

This block is the on-chip scratch memory of a small matrix engine. It holds operand matrices, weights, bias vectors, saved activations and scalar constants. Hosts fill it through two 16-bit write channels. Each channel has its own valid flag. Words land at consecutive addresses taken from an internal write pointer.

Reads are bursts, not single-word accesses. A one-cycle start pulse carries a base address, a row count, a column count, an order flag and a 3-bit destination code. The buffer then walks the rows × columns tile on its own and delivers two words per cycle: lane A carries the even-numbered elements of the walk and lane B the odd-numbered ones. It keeps going until the element count is used up. In row order the walk runs row-major. In column order it runs column-major, and the column count serves as the row stride. Every delivered word is tagged with a one-hot strobe that selects the consumer named by the destination code.

Top module: `unified_buffer`

## Requirements
- R1: After reset, `busy`, `out_vld_a`, `out_vld_b` and `out_route` are all zero, and the write pointer is at address 0.
- R2: A host write with a single channel valid stores its word at the write pointer, which then advances by one. The pointer wraps from 255 to 0.
- R3: When both channels are valid in one cycle, channel A's word goes to the pointer and channel B's word to the pointer plus one, and the pointer advances by two.
- R4: With `rd_order` = 0 (row order), element k of the burst is read from address `rd_base` + k. Lane A carries element 2j and lane B element 2j+1 in the j-th output cycle. The first output cycle is the second cycle after the clock edge that samples the start pulse.
- R5: With `rd_order` = 1 (column order), element k is read from address `rd_base` + r·`rd_cols` + c, with r running fastest: r = k mod `rd_rows` and c = k div `rd_rows`.
- R6: A burst of n = `rd_rows`·`rd_cols` elements takes ceil(n/2) output cycles. When n is odd, lane B is not valid in the last cycle.
- R7: `busy` rises at the edge that samples an accepted start. It stays high through the cycle before the last output cycle and is low during the last output cycle.
- R8: A start pulse sampled while `busy` is high is ignored. The running burst and its destination do not change.
- R9: A start with `rd_rows` = 0 or `rd_cols` = 0 produces no output and leaves `busy` low.
- R10: While lane A is valid, `out_route` has exactly the bit numbered by the `rd_route` value captured at start set. Otherwise it is zero. Changes to the request inputs after the start cycle have no effect.
- R11: Read addresses wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld_a | input | 1 | Host channel A write valid |
| wr_data_a | input | 16 | Host channel A write word |
| wr_vld_b | input | 1 | Host channel B write valid |
| wr_data_b | input | 16 | Host channel B write word |
| rd_start | input | 1 | One-cycle burst launch |
| rd_order | input | 1 | 0 row-major walk, 1 column-major walk |
| rd_base | input | 8 | Burst base address |
| rd_rows | input | 8 | Tile row count |
| rd_cols | input | 2 | Tile column count |
| rd_route | input | 3 | Destination code |
| busy | output | 1 | Burst address phase active |
| out_vld_a | output | 1 | Lane A word valid |
| out_data_a | output | 16 | Lane A word |
| out_vld_b | output | 1 | Lane B word valid |
| out_data_b | output | 16 | Lane B word |
| out_route | output | 8 | One-hot destination strobe |

## Verification
A wrong position counter in the sequencer shows up as a wrong word on a lane in the first output cycle after the slip. This is why every burst word is compared against a bench-side memory model with known fill data. A bad remaining-count register shows up one cycle early or late as a `busy` or lane B mismatch in the last output cycle. A corrupted write pointer shows up only when that region is read back, so the fill pattern is checked across the wrap point and the dual-write pairs. A bad route latch appears on the very first output cycle, because the bench changes the request inputs right after the start pulse.

// File: rtl/ub_pkg.sv
// Package: shared types for the scratch buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package ub_pkg;
    // Tile walk order chosen at burst start.
    typedef enum logic {
        WALK_ROW = 1'b0,
        WALK_COL = 1'b1
    } walk_e;
endpackage

// File: rtl/ub_store.sv
// Module: ub_store
// Storage array with two write ports and NRD registered read ports.
// Assumes: both write addresses differ whenever both enables are high
// (guaranteed by the write pointer logic). A read of an address written
// at the same edge returns the old word.
module ub_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] waddr_a,
    input  logic [DATA_W-1:0] wdata_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] waddr_b,
    input  logic [DATA_W-1:0] wdata_b,
    input  logic [ADDR_W-1:0] raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Apply both host write ports in one edge.
    always_ff @(posedge clk) begin
        if (we_a) mem[waddr_a] <= wdata_a;
        if (we_b) mem[waddr_b] <= wdata_b;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Registered read for port p.
        always_ff @(posedge clk) begin
            rdata[p] <= mem[raddr[p]];
        end
    end
endmodule

// File: rtl/ub_wr_ctrl.sv
// Module: ub_wr_ctrl
// Write pointer for the two host channels. Channel A takes the lower
// address when both are valid.
// Assumes: the pointer wraps modulo the memory depth.
module ub_wr_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_a,
    input  logic              vld_b,
    output logic [ADDR_W-1:0] waddr_a,
    output logic [ADDR_W-1:0] waddr_b
);
    logic [ADDR_W-1:0] ptr_q;

    // Channel B lands one past channel A when both write.
    always_comb begin
        waddr_a = ptr_q;
        waddr_b = vld_a ? ptr_q + ADDR_W'(1) : ptr_q;
    end

    // Advance the pointer by the number of accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_q + ADDR_W'(vld_a) + ADDR_W'(vld_b);
    end
endmodule

// File: rtl/ub_burst_seq.sv
// Module: ub_burst_seq
// Burst sequencer: captures a tile request and produces two consecutive
// walk addresses per cycle until the element count is used up.
// Assumes: requests that arrive while busy are dropped; zero-size tiles
// never start.
module ub_burst_seq
    import ub_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int ROWS_W  = 8,
    parameter int COLS_W  = 2,
    parameter int ROUTE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  walk_e              walk,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ROWS_W-1:0]  rows,
    input  logic [COLS_W-1:0]  cols,
    input  logic [ROUTE_W-1:0] route,
    output logic               busy,
    output logic               pair_ok,
    output logic [ADDR_W-1:0]  addr_a,
    output logic [ADDR_W-1:0]  addr_b,
    output logic [ROUTE_W-1:0] route_q
);
    localparam int CNT_W = ROWS_W + COLS_W;

    logic [ADDR_W-1:0] base_q;
    logic [ROWS_W-1:0] rows_q, r_q, r1, r2;
    logic [COLS_W-1:0] cols_q, c_q, c1, c2;
    walk_e             walk_q;
    logic [CNT_W-1:0]  rem_q, req_cnt;

    // Next tile position in the chosen walk order.
    function automatic logic [CNT_W-1:0] step(
        input logic [ROWS_W-1:0] r, input logic [COLS_W-1:0] c,
        input logic [ROWS_W-1:0] nr, input logic [COLS_W-1:0] nc,
        input walk_e w);
        logic [ROWS_W-1:0] rn;
        logic [COLS_W-1:0] cn;
        rn = r;
        cn = c;
        if (w == WALK_ROW) begin
            if (c == nc - COLS_W'(1)) begin
                cn = '0;
                rn = r + ROWS_W'(1);
            end else begin
                cn = c + COLS_W'(1);
            end
        end else begin
            if (r == nr - ROWS_W'(1)) begin
                rn = '0;
                cn = c + COLS_W'(1);
            end else begin
                rn = r + ROWS_W'(1);
            end
        end
        return {rn, cn};
    endfunction

    // Linear address of a tile position, wrapping modulo memory depth.
    function automatic logic [ADDR_W-1:0] locate(
        input logic [ADDR_W-1:0] b, input logic [ROWS_W-1:0] r,
        input logic [COLS_W-1:0] c, input logic [COLS_W-1:0] nc);
        logic [CNT_W-1:0] off;
        off = CNT_W'(r) * CNT_W'(nc) + CNT_W'(c);
        return b + ADDR_W'(off);
    endfunction

    // Lane positions for this cycle and the position two steps on.
    always_comb begin
        {r1, c1} = step(r_q, c_q, rows_q, cols_q, walk_q);
        {r2, c2} = step(r1, c1, rows_q, cols_q, walk_q);
        addr_a   = locate(base_q, r_q, c_q, cols_q);
        addr_b   = locate(base_q, r1, c1, cols_q);
        pair_ok  = rem_q >= CNT_W'(2);
        req_cnt  = CNT_W'(rows) * CNT_W'(cols);
    end

    // Accept a request when idle, else advance two elements per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rem_q   <= '0;
            r_q     <= '0;
            c_q     <= '0;
            rows_q  <= '0;
            cols_q  <= '0;
            base_q  <= '0;
            walk_q  <= WALK_ROW;
            route_q <= '0;
        end else if (!busy) begin
            if (start && req_cnt != '0) begin
                busy    <= 1'b1;
                rem_q   <= req_cnt;
                r_q     <= '0;
                c_q     <= '0;
                rows_q  <= rows;
                cols_q  <= cols;
                base_q  <= base;
                walk_q  <= walk;
                route_q <= route;
            end
        end else begin
            r_q <= r2;
            c_q <= c2;
            if (rem_q <= CNT_W'(2)) begin
                busy  <= 1'b0;
                rem_q <= '0;
            end else begin
                rem_q <= rem_q - CNT_W'(2);
            end
        end
    end
endmodule

// File: rtl/unified_buffer.sv
// Module: unified_buffer (top)
// Scratch buffer with two host write channels and a self-running burst
// reader delivering two words per cycle with a one-hot destination strobe.
// Assumes: consumers accept every delivered word (no back-pressure).
module unified_buffer
    import ub_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 8,
    parameter int ROWS_W  = 8,
    parameter int COLS_W  = 2,
    parameter int ROUTE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_vld_a,
    input  logic [DATA_W-1:0]          wr_data_a,
    input  logic                       wr_vld_b,
    input  logic [DATA_W-1:0]          wr_data_b,
    input  logic                       rd_start,
    input  logic                       rd_order,
    input  logic [ADDR_W-1:0]          rd_base,
    input  logic [ROWS_W-1:0]          rd_rows,
    input  logic [COLS_W-1:0]          rd_cols,
    input  logic [ROUTE_W-1:0]         rd_route,
    output logic                       busy,
    output logic                       out_vld_a,
    output logic [DATA_W-1:0]          out_data_a,
    output logic                       out_vld_b,
    output logic [DATA_W-1:0]          out_data_b,
    output logic [(1<<ROUTE_W)-1:0]    out_route
);
    localparam int NDEST = 1 << ROUTE_W;
    localparam int NRD   = 2;

    logic [ADDR_W-1:0]  waddr_a, waddr_b;
    logic [ADDR_W-1:0]  raddr [NRD];
    logic [DATA_W-1:0]  rdata [NRD];
    logic               pair_ok;
    logic [ROUTE_W-1:0] route_q;
    walk_e              walk_in;

    assign walk_in = walk_e'(rd_order);

    ub_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_a   (wr_vld_a),
        .vld_b   (wr_vld_b),
        .waddr_a (waddr_a),
        .waddr_b (waddr_b)
    );

    ub_burst_seq #(
        .ADDR_W (ADDR_W),
        .ROWS_W (ROWS_W),
        .COLS_W (COLS_W),
        .ROUTE_W(ROUTE_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_start),
        .walk    (walk_in),
        .base    (rd_base),
        .rows    (rd_rows),
        .cols    (rd_cols),
        .route   (rd_route),
        .busy    (busy),
        .pair_ok (pair_ok),
        .addr_a  (raddr[0]),
        .addr_b  (raddr[1]),
        .route_q (route_q)
    );

    ub_store #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .NRD   (NRD)
    ) u_mem (
        .clk     (clk),
        .we_a    (wr_vld_a),
        .waddr_a (waddr_a),
        .wdata_a (wr_data_a),
        .we_b    (wr_vld_b),
        .waddr_b (waddr_b),
        .wdata_b (wr_data_b),
        .raddr   (raddr),
        .rdata   (rdata)
    );

    assign out_data_a = rdata[0];
    assign out_data_b = rdata[1];

    // Align lane valids and destination strobe with the registered reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_a <= 1'b0;
            out_vld_b <= 1'b0;
            out_route <= '0;
        end else begin
            out_vld_a <= busy;
            out_vld_b <= busy & pair_ok;
            out_route <= busy ? (NDEST'(1) << route_q) : '0;
        end
    end
endmodule

// File: rtl/ub_checker.sv
// Module: ub_checker
// Protocol properties for unified_buffer, observed at its ports.
// Assumes: attached through the bind below.
module ub_checker #(
    parameter int ROWS_W = 8,
    parameter int COLS_W = 2,
    parameter int NDEST  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_start,
    input logic [ROWS_W-1:0] rd_rows,
    input logic [COLS_W-1:0] rd_cols,
    input logic              busy,
    input logic              out_vld_a,
    input logic              out_vld_b,
    input logic [NDEST-1:0]  out_route
);
    // R4: output words only follow an address-phase cycle.
    a_r4_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_a |-> $past(busy));

    // R6: lane B never runs without lane A.
    a_r6_lane_b_with_a: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_b |-> out_vld_a);

    // R10: exactly one destination while data flows.
    a_r10_route_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_a |-> $countones(out_route) == 1);

    // R10: no destination strobe without data.
    a_r10_route_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld_a |-> out_route == '0);

    // R8 and R10: destination is fixed within a burst.
    a_r8_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_a && $past(out_vld_a)) |-> $stable(out_route));

    // R7: an accepted non-empty start raises busy.
    a_r7_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy && rd_rows != '0 && rd_cols != '0) |=> busy);

    // R9: an empty tile does not start.
    a_r9_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !busy && (rd_rows == '0 || rd_cols == '0)) |=> !busy);
endmodule

bind unified_buffer ub_checker #(
    .ROWS_W(ROWS_W),
    .COLS_W(COLS_W),
    .NDEST (1 << ROUTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .rd_rows  (rd_rows),
    .rd_cols  (rd_cols),
    .busy     (busy),
    .out_vld_a(out_vld_a),
    .out_vld_b(out_vld_b),
    .out_route(out_route)
);

// File: tb/sim_unified_buffer.sv
// Bench for unified_buffer: fills memory through both channels, then walks
// a table of burst requests and compares every lane against a model.
module sim_unified_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld_a = 1'b0, wr_vld_b = 1'b0;
    logic [15:0] wr_data_a = '0, wr_data_b = '0;
    logic        rd_start = 1'b0, rd_order = 1'b0;
    logic [7:0]  rd_base = '0, rd_rows = '0;
    logic [1:0]  rd_cols = '0;
    logic [2:0]  rd_route = '0;
    logic        busy, out_vld_a, out_vld_b;
    logic [15:0] out_data_a, out_data_b;
    logic [7:0]  out_route;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] mdl [256];
    int mdl_ptr = 0;
    int seq [1024];

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] rows;
        logic [1:0] cols;
        logic       order;
        logic [2:0] route;
        logic       poke;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{8'd0,   8'd2, 2'd3, 1'b0, 3'd1, 1'b0},
        '{8'd16,  8'd3, 2'd3, 1'b1, 3'd5, 1'b0},
        '{8'd40,  8'd3, 2'd1, 1'b0, 3'd0, 1'b0},
        '{8'd250, 8'd4, 2'd3, 1'b0, 3'd7, 1'b0},
        '{8'd100, 8'd5, 2'd2, 1'b1, 3'd2, 1'b1},
        '{8'd200, 8'd8, 2'd2, 1'b1, 3'd3, 1'b0},
        '{8'd7,   8'd1, 2'd1, 1'b0, 3'd4, 1'b0}
    };

    unified_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_vld_a(wr_vld_a), .wr_data_a(wr_data_a),
        .wr_vld_b(wr_vld_b), .wr_data_b(wr_data_b),
        .rd_start(rd_start), .rd_order(rd_order), .rd_base(rd_base),
        .rd_rows(rd_rows), .rd_cols(rd_cols), .rd_route(rd_route),
        .busy(busy), .out_vld_a(out_vld_a), .out_data_a(out_data_a),
        .out_vld_b(out_vld_b), .out_data_b(out_data_b), .out_route(out_route)
    );

    always #5 clk = ~clk;

    // Record one comparison.
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One host write cycle; the model follows the pointer rules of R2/R3.
    task automatic host_wr(input bit va, input logic [15:0] da,
                           input bit vb, input logic [15:0] db);
        @(negedge clk);
        wr_vld_a = va; wr_data_a = da;
        wr_vld_b = vb; wr_data_b = db;
        if (va) begin mdl[mdl_ptr] = da; mdl_ptr = (mdl_ptr + 1) % 256; end
        if (vb) begin mdl[mdl_ptr] = db; mdl_ptr = (mdl_ptr + 1) % 256; end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2/R3/R4";
            1: return "R5";
            2: return "R6";
            3: return "R11";
            4: return "R8";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Launch one burst and check every output cycle (R4 R6 R7 R10).
    task automatic run_burst(input vec_t v, input string tag);
        int n, np;
        n = int'(v.rows) * int'(v.cols);
        np = (n + 1) / 2;
        if (v.order == 1'b0) begin
            for (int k = 0; k < n; k++) seq[k] = (int'(v.base) + k) % 256;
        end else begin
            for (int c = 0; c < int'(v.cols); c++)
                for (int r = 0; r < int'(v.rows); r++)
                    seq[c*int'(v.rows) + r] =
                        (int'(v.base) + r*int'(v.cols) + c) % 256;
        end
        @(negedge clk);
        rd_start = 1'b1; rd_order = v.order; rd_base = v.base;
        rd_rows = v.rows; rd_cols = v.cols; rd_route = v.route;
        @(negedge clk);
        // Disturb the request inputs (R10); optionally re-start (R8).
        rd_start = v.poke; rd_route = ~v.route; rd_base = ~v.base;
        rd_rows = 8'd1; rd_cols = 2'd1; rd_order = ~v.order;
        chk(busy == (n > 0), tag, "busy after start R7", 32'(busy), 32'(n > 0));
        chk(!out_vld_a, tag, "no data yet R4", 32'(out_vld_a), 0);
        for (int p = 0; p < np; p++) begin
            @(negedge clk);
            rd_start = 1'b0;
            chk(out_vld_a, tag, "lane A valid", 32'(out_vld_a), 1);
            chk(out_data_a == mdl[seq[2*p]], tag, "lane A word",
                32'(out_data_a), 32'(mdl[seq[2*p]]));
            chk(out_route == (8'd1 << v.route), tag, "route R10",
                32'(out_route), 32'(8'd1 << v.route));
            chk(out_vld_b == (2*p + 1 < n), tag, "lane B valid R6",
                32'(out_vld_b), 32'(2*p + 1 < n));
            if (2*p + 1 < n)
                chk(out_data_b == mdl[seq[2*p+1]], tag, "lane B word",
                    32'(out_data_b), 32'(mdl[seq[2*p+1]]));
            chk(busy == (p < np - 1), tag, "busy span R7",
                32'(busy), 32'(p < np - 1));
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            rd_start = 1'b0;
            chk(!out_vld_a && !out_vld_b && !busy && out_route == '0, tag,
                "idle after burst", {out_vld_a, out_vld_b, busy, out_route}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk(!busy && !out_vld_a && !out_vld_b && out_route == '0, "R1",
            "reset outputs", {busy, out_vld_a, out_vld_b, out_route}, 0);
        rst_n = 1'b1;
        // R2: single-channel writes, R3: paired writes, wrap after 256.
        for (int i = 0; i < 3; i++) host_wr(1'b1, 16'hC000 + 16'(i), 1'b0, '0);
        host_wr(1'b0, '0, 1'b1, 16'hD003);
        for (int i = 4; i < 256; i += 2)
            host_wr(1'b1, 16'(i) * 16'h0101 ^ 16'h5A3C,
                    1'b1, 16'(i + 1) * 16'h0101 ^ 16'h5A3C);
        host_wr(1'b0, '0, 1'b1, 16'hBEEF);
        @(negedge clk);
        wr_vld_a = 1'b0; wr_vld_b = 1'b0;
        chk(mdl[0] == 16'hBEEF && mdl[4] == (16'h0404 ^ 16'h5A3C), "R2",
            "model pointer wrap", 32'(mdl[0]), 32'h0000BEEF);
        for (int i = 0; i < 7; i++) run_burst(VECS[i], vec_tag(i));
        // R9: empty tiles leave the block idle.
        run_burst('{8'd30, 8'd0, 2'd3, 1'b0, 3'd6, 1'b0}, "R9");
        run_burst('{8'd30, 8'd5, 2'd0, 1'b1, 3'd6, 1'b0}, "R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule